// File: doc/BRIEF.md
# LCD Pixel Clock and Video Enable Control

This block sits at the front of an LCD video controller. It derives the pixel clock from one of two source clocks and decides whether the video logic runs. Both sources arrive as single-cycle tick enables in the block's own clock domain. A configuration write carries every control field at once: the source code, direct or divided mode, a divider value, a flag that defers the divider to the next frame start, a clock-output enable and a 2-bit video enable code.

The pixel clock leaves the block in two forms. One is a one-cycle strobe at the start of each pixel period. The other is a level that flips on every strobe. An external timing generator supplies frame-start and frame-end strobes. A frame start commits a deferred divider value. A frame end completes a deferred shutdown. The live video enable state can be read back, and the readback shows a deferred shutdown as still running until the frame boundary.

Top module: `lcd_pclk_ctrl`

## Requirements
- R1: After reset, `pclk_stb`, `pclk_lvl` and `video_on` are 0 and `vid_state_rd` is 2'b00. The configuration is source 00, direct mode, divider 0 and clock disabled.
- R2: `cfg_src` 2'b00 selects `sys_tick` and 2'b01 selects `vid_tick`. Codes 2'b10 and 2'b11 select nothing, so no strobes are produced.
- R3: In direct mode (`cfg_divided`=0), every selected source tick gives one `pclk_stb` pulse in the cycle after the tick is sampled.
- R4: In divided mode, a strobe is produced every divider+1 source ticks. A divider of 0 in divided mode behaves like direct mode.
- R5: A write with `cfg_upd_frame`=0 applies the divider at once and restarts the division count, so the first strobe comes after exactly divider+1 further ticks. A change of source or mode also restarts the count.
- R6: A write with `cfg_upd_frame`=1 stores the divider as pending. The old divider stays in use until the next `frame_start`, which applies the pending value once and restarts the count. A later `frame_start` with nothing pending changes nothing.
- R7: With `cfg_clk_en`=0, no strobes occur and `pclk_lvl` is held at 0. With the clock enabled, `pclk_lvl` inverts on each strobe.
- R8: Video code 2'b11 turns `video_on` on and code 2'b00 turns it off from the next cycle. Readback then shows 2'b11 or 2'b00 respectively.
- R9: Code 2'b10 written while video is on keeps `video_on` at 1 and readback at 2'b11 until the next `frame_end`. After that frame end, `video_on` is 0 and readback is 2'b10.
- R10: Code 2'b01 leaves the video state and readback unchanged. Code 2'b10 written while video is off keeps it off and makes readback 2'b10.
- R11: Code 2'b00 written while a deferred shutdown is pending cancels it. Video stops at once, readback is 2'b00, and the next `frame_end` changes nothing.
- R12: When a video code other than 2'b01 is written in the same cycle as `frame_end`, the write decides the next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_tick | input | 1 | Tick enable of the system bus clock source |
| vid_tick | input | 1 | Tick enable of the dedicated video clock source |
| cfg_wr | input | 1 | Configuration write strobe; all cfg_* fields are sampled with it |
| cfg_src | input | 2 | Source code: 00 system, 01 video, 1x none |
| cfg_divided | input | 1 | 0 direct, 1 divided |
| cfg_div | input | DIV_W | Divider value |
| cfg_upd_frame | input | 1 | 1 defers the divider to the next frame start |
| cfg_clk_en | input | 1 | Pixel clock output enable |
| cfg_vid | input | 2 | Video code: 11 on, 00 off now, 10 off at frame end, 01 no change |
| frame_start | input | 1 | Frame start strobe from the timing generator |
| frame_end | input | 1 | Frame end strobe from the timing generator |
| pclk_stb | output | 1 | One-cycle strobe per pixel period |
| pclk_lvl | output | 1 | Pixel clock level, inverted on each strobe |
| video_on | output | 1 | Video logic enable |
| vid_state_rd | output | 2 | Readback of the live video enable code |

## Verification
The bench counts strobes over fixed windows of ticks for each source, mode and divider. An off-by-one divider would give divider or divider+2 periods, and a wrong source mux would count the other tick stream or count ticks under a reserved code. For the deferred divider, it checks that the old rate holds until a frame start and that the new rate is applied once, cleanly. A design that applied the value at the write, or never applied it, gives the wrong count in one of those windows. The enable tests cover a shutdown that drains at the frame end, cancelling it with an immediate disable, reserved codes, and a write that coincides with a frame end. A design with the wrong priority, or with a readback that dropped to 2'b10 too early, fails at those points.

// File: rtl/lcd_pclk_pkg.sv
package lcd_pclk_pkg;

    localparam int SRC_W = 2;
    localparam int NUM_SRC = 2;

    localparam logic [1:0] VCODE_OFF   = 2'b00;
    localparam logic [1:0] VCODE_RSVD  = 2'b01;
    localparam logic [1:0] VCODE_DEFER = 2'b10;
    localparam logic [1:0] VCODE_ON    = 2'b11;

    typedef enum logic [1:0] {
        VS_OFF    = 2'd0,
        VS_PARKED = 2'd1,
        VS_RUN    = 2'd2,
        VS_DRAIN  = 2'd3
    } vstate_e;

endpackage

// File: rtl/lcd_tick_mux.sv
module lcd_tick_mux #(
    parameter int NUM_SRC = 2,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_SRC-1:0] ticks,
    input  logic [SEL_W-1:0]   sel,
    output logic               tick_out
);
    logic [NUM_SRC-1:0] hit;

    // codes at or above NUM_SRC match no source
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = ticks[g] && (sel == SEL_W'(g));
    end

    assign tick_out = |hit;

endmodule

// File: rtl/lcd_pclk_div.sv
module lcd_pclk_div #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enable,
    input  logic             divided,
    input  logic [DIV_W-1:0] div_val,
    input  logic             restart,
    output logic             stb,
    output logic             lvl
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             stb;
        logic             lvl;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    period_hit;

    // a zero divider in divided mode hits on every tick
    assign period_hit = !divided || (st_q.cnt >= div_val);

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (!enable) begin
            st_d.cnt = '0;
            st_d.lvl = 1'b0;
        end else if (restart) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (period_hit) begin
                st_d.cnt = '0;
                st_d.stb = 1'b1;
                st_d.lvl = ~st_q.lvl;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stb = st_q.stb;
    assign lvl = st_q.lvl;

endmodule

// File: rtl/lcd_vid_enable.sv
module lcd_vid_enable
    import lcd_pclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] code,
    input  logic       frame_end,
    output logic       video_on,
    output logic [1:0] state_rd
);
    vstate_e vs_d, vs_q;

    always_comb begin
        vs_d = vs_q;
        if (frame_end && vs_q == VS_DRAIN) vs_d = VS_PARKED;
        // a non-reserved write overrides the frame end rule
        if (wr) begin
            unique case (code)
                VCODE_ON:    vs_d = VS_RUN;
                VCODE_OFF:   vs_d = VS_OFF;
                VCODE_DEFER: vs_d = (vs_q == VS_RUN || vs_q == VS_DRAIN) ? VS_DRAIN : VS_PARKED;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vs_q <= VS_OFF;
        else        vs_q <= vs_d;
    end

    always_comb begin
        unique case (vs_q)
            VS_OFF:    state_rd = VCODE_OFF;
            VS_PARKED: state_rd = VCODE_DEFER;
            default:   state_rd = VCODE_ON;
        endcase
    end

    assign video_on = (vs_q == VS_RUN) || (vs_q == VS_DRAIN);

endmodule

// File: rtl/lcd_pclk_ctrl.sv
module lcd_pclk_ctrl
    import lcd_pclk_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_tick,
    input  logic             vid_tick,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_src,
    input  logic             cfg_divided,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_upd_frame,
    input  logic             cfg_clk_en,
    input  logic [1:0]       cfg_vid,
    input  logic             frame_start,
    input  logic             frame_end,
    output logic             pclk_stb,
    output logic             pclk_lvl,
    output logic             video_on,
    output logic [1:0]       vid_state_rd
);
    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic             divided;
        logic             clk_en;
        logic [DIV_W-1:0] div_act;
        logic [DIV_W-1:0] div_pend;
        logic             pend_v;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic restart;
    logic src_tick;

    always_comb begin
        cfg_d   = cfg_q;
        restart = 1'b0;
        // commit a deferred divider at the frame boundary
        if (frame_start && cfg_q.pend_v) begin
            cfg_d.div_act = cfg_q.div_pend;
            cfg_d.pend_v  = 1'b0;
            restart       = 1'b1;
        end
        if (cfg_wr) begin
            cfg_d.src     = cfg_src;
            cfg_d.divided = cfg_divided;
            cfg_d.clk_en  = cfg_clk_en;
            if (cfg_src != cfg_q.src || cfg_divided != cfg_q.divided) restart = 1'b1;
            if (cfg_upd_frame) begin
                cfg_d.div_pend = cfg_div;
                cfg_d.pend_v   = 1'b1;
            end else begin
                cfg_d.div_act = cfg_div;
                cfg_d.pend_v  = 1'b0;
                restart       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    lcd_tick_mux #(
        .NUM_SRC (NUM_SRC),
        .SEL_W   (SRC_W)
    ) u_mux (
        .ticks    ({vid_tick, sys_tick}),
        .sel      (cfg_q.src),
        .tick_out (src_tick)
    );

    lcd_pclk_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (src_tick),
        .enable  (cfg_q.clk_en),
        .divided (cfg_q.divided),
        .div_val (cfg_q.div_act),
        .restart (restart),
        .stb     (pclk_stb),
        .lvl     (pclk_lvl)
    );

    lcd_vid_enable u_ven (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .code      (cfg_vid),
        .frame_end (frame_end),
        .video_on  (video_on),
        .state_rd  (vid_state_rd)
    );

endmodule

// File: rtl/lcd_pclk_ctrl_chk.sv
module lcd_pclk_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic [1:0] cfg_vid,
    input logic       frame_end,
    input logic       pclk_stb,
    input logic       pclk_lvl,
    input logic       video_on,
    input logic [1:0] vid_state_rd,
    input logic       clk_en_q,
    input logic [1:0] src_q
);
    a_r2_reserved_src_silent: assert property (@(posedge clk) disable iff (!rst_n)
        src_q[1] |=> !pclk_stb);

    a_r7_off_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en_q |=> !pclk_stb && !pclk_lvl);

    a_r7_level_rises_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pclk_lvl) && pclk_lvl) |-> pclk_stb);

    a_r8_on_code: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_vid == 2'b11) |=> video_on && vid_state_rd == 2'b11);

    a_r8_off_code: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_vid == 2'b00) |=> !video_on && vid_state_rd == 2'b00);

    a_r9_defer_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_vid == 2'b10 && video_on) |=> video_on && vid_state_rd == 2'b11);

    a_r10_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_vid == 2'b01 && !frame_end) |=> $stable(vid_state_rd));

endmodule

bind lcd_pclk_ctrl lcd_pclk_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .cfg_vid      (cfg_vid),
    .frame_end    (frame_end),
    .pclk_stb     (pclk_stb),
    .pclk_lvl     (pclk_lvl),
    .video_on     (video_on),
    .vid_state_rd (vid_state_rd),
    .clk_en_q     (cfg_q.clk_en),
    .src_q        (cfg_q.src)
);

// File: tb/lcd_pclk_ctrl_bench.sv
module lcd_pclk_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W = 6;

    typedef struct packed {
        logic       en;
        logic [1:0] src;
        logic       divd;
        logic [5:0] div;
        logic [7:0] exp;
    } vec_t;

    // 60 sys ticks, 20 vid ticks per window
    localparam int NVEC = 12;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 2'd0, 1'b0, 6'd5,  8'd60},
        '{1'b1, 2'd0, 1'b1, 6'd1,  8'd30},
        '{1'b1, 2'd0, 1'b1, 6'd4,  8'd12},
        '{1'b1, 2'd0, 1'b1, 6'd7,  8'd7},
        '{1'b1, 2'd0, 1'b1, 6'd59, 8'd1},
        '{1'b1, 2'd1, 1'b0, 6'd0,  8'd20},
        '{1'b1, 2'd1, 1'b1, 6'd3,  8'd5},
        '{1'b1, 2'd1, 1'b1, 6'd0,  8'd20},
        '{1'b1, 2'd2, 1'b0, 6'd0,  8'd0},
        '{1'b1, 2'd3, 1'b1, 6'd2,  8'd0},
        '{1'b0, 2'd0, 1'b0, 6'd0,  8'd0},
        '{1'b1, 2'd0, 1'b1, 6'd63, 8'd0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sys_tick = 1'b0, vid_tick = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [1:0]       cfg_src = '0;
    logic             cfg_divided = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic             cfg_upd_frame = 1'b0;
    logic             cfg_clk_en = 1'b0;
    logic [1:0]       cfg_vid = 2'b01;
    logic             frame_start = 1'b0, frame_end = 1'b0;
    logic             pclk_stb, pclk_lvl, video_on;
    logic [1:0]       vid_state_rd;

    int total = 0;
    int bad = 0;
    int cnt;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lcd_pclk_ctrl #(.DIV_W(DIV_W)) u_lcd_pclk_ctrl (
        .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .vid_tick(vid_tick),
        .cfg_wr(cfg_wr), .cfg_src(cfg_src), .cfg_divided(cfg_divided),
        .cfg_div(cfg_div), .cfg_upd_frame(cfg_upd_frame), .cfg_clk_en(cfg_clk_en),
        .cfg_vid(cfg_vid), .frame_start(frame_start), .frame_end(frame_end),
        .pclk_stb(pclk_stb), .pclk_lvl(pclk_lvl), .video_on(video_on),
        .vid_state_rd(vid_state_rd)
    );

    task automatic check(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic en, input logic [1:0] src, input logic divd,
                             input logic [5:0] div, input logic upd,
                             input logic [1:0] vid, input logic fe);
        cfg_wr = 1'b1; cfg_clk_en = en; cfg_src = src; cfg_divided = divd;
        cfg_div = div; cfg_upd_frame = upd; cfg_vid = vid; frame_end = fe;
        @(negedge clk);
        cfg_wr = 1'b0; frame_end = 1'b0; cfg_vid = 2'b01;
    endtask

    task automatic run_ticks(input int n);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            sys_tick = 1'b1;
            vid_tick = (i % 3 == 0);
            @(negedge clk);
            cnt += int'(pclk_stb);
        end
        sys_tick = 1'b0; vid_tick = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            cnt += int'(pclk_stb);
        end
    endtask

    task automatic pulse(input bit start);
        if (start) frame_start = 1'b1; else frame_end = 1'b1;
        @(negedge clk);
        frame_start = 1'b0; frame_end = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(pclk_stb, 0, "R1 stb");
        check(pclk_lvl, 0, "R1 lvl");
        check(video_on, 0, "R1 video_on");
        check(vid_state_rd, 0, "R1 readback");
        rst_n = 1'b1;
        @(negedge clk);
        run_ticks(10);
        check(cnt, 0, "R1 clock off after reset");

        // R2 R3 R4 R5: vector walk (immediate writes restart the count)
        foreach (VEC[k]) begin
            write_cfg(VEC[k].en, VEC[k].src, VEC[k].divd, VEC[k].div, 1'b0, 2'b01, 1'b0);
            run_ticks(60);
            check(cnt, int'(VEC[k].exp), $sformatf("R2/R3/R4/R5 vector %0d", k));
        end

        // R7 level held low when disabled, toggles per strobe
        check(pclk_lvl, 0, "R7 level low with clock off");
        write_cfg(1'b1, 2'd0, 1'b0, 6'd0, 1'b0, 2'b01, 1'b0);
        run_ticks(3);
        check(pclk_lvl, 1, "R7 level after three strobes");

        // R6 deferred divider
        write_cfg(1'b1, 2'd0, 1'b1, 6'd1, 1'b0, 2'b01, 1'b0);
        run_ticks(4);
        check(cnt, 2, "R5 divider 1 immediate");
        write_cfg(1'b1, 2'd0, 1'b1, 6'd3, 1'b1, 2'b01, 1'b0);
        run_ticks(6);
        check(cnt, 3, "R6 old divider before frame start");
        pulse(1'b1);
        run_ticks(8);
        check(cnt, 2, "R6 new divider after frame start");
        pulse(1'b1);
        run_ticks(8);
        check(cnt, 2, "R6 second frame start no change");

        // R8 on / off
        write_cfg(1'b1, 2'd0, 1'b1, 6'd3, 1'b0, 2'b11, 1'b0);
        check(video_on, 1, "R8 on");
        check(vid_state_rd, 3, "R8 readback on");
        // R9 deferred shutdown
        write_cfg(1'b1, 2'd0, 1'b1, 6'd3, 1'b0, 2'b10, 1'b0);
        repeat (3) @(negedge clk);
        check(video_on, 1, "R9 still on before frame end");
        check(vid_state_rd, 3, "R9 readback 11 while draining");
        pulse(1'b0);
        check(video_on, 0, "R9 off after frame end");
        check(vid_state_rd, 2, "R9 readback 10 after frame end");
        // R11 cancel
        write_cfg(1'b1, 2'd0, 1'b1, 6'd3, 1'b0, 2'b11, 1'b0);
        write_cfg(1'b1, 2'd0, 1'b1, 6'd3, 1'b0, 2'b10, 1'b0);
        write_cfg(1'b1, 2'd0, 1'b1, 6'd3, 1'b0, 2'b00, 1'b0);
        check(video_on, 0, "R11 off at once");
        pulse(1'b0);
        check(vid_state_rd, 0, "R11 frame end after cancel");
        // R10 reserved and defer while off
        write_cfg(1'b1, 2'd0, 1'b1, 6'd3, 1'b0, 2'b01, 1'b0);
        check(vid_state_rd, 0, "R10 reserved keeps off");
        write_cfg(1'b1, 2'd0, 1'b1, 6'd3, 1'b0, 2'b11, 1'b0);
        write_cfg(1'b1, 2'd0, 1'b1, 6'd3, 1'b0, 2'b01, 1'b0);
        check(vid_state_rd, 3, "R10 reserved keeps on");
        write_cfg(1'b1, 2'd0, 1'b1, 6'd3, 1'b0, 2'b00, 1'b0);
        write_cfg(1'b1, 2'd0, 1'b1, 6'd3, 1'b0, 2'b10, 1'b0);
        check(video_on, 0, "R10 defer while off stays off");
        check(vid_state_rd, 2, "R10 defer while off readback");
        // R12 write wins over coincident frame end
        write_cfg(1'b1, 2'd0, 1'b1, 6'd3, 1'b0, 2'b11, 1'b0);
        write_cfg(1'b1, 2'd0, 1'b1, 6'd3, 1'b0, 2'b10, 1'b0);
        write_cfg(1'b1, 2'd0, 1'b1, 6'd3, 1'b0, 2'b11, 1'b1);
        check(video_on, 1, "R12 on write beats frame end");
        pulse(1'b0);
        check(vid_state_rd, 3, "R12 later frame end no effect");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule